// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Control Registers

This block holds the software-visible control state of one bus-master disk DMA channel. It has three registers: a command register with a start bit and a direction bit, a status register, and the base address of the descriptor table. The host reaches them through a byte-addressed register port that carries a register select, a byte offset and an access width of one, two or four bytes. The descriptor walker next to this block receives several signals from it: the active flag, the direction, the table base, a one-cycle pulse that reloads the walker's current descriptor pointer, and a one-cycle pulse that starts a new transfer.

The start bit acts only on a change of value. When it goes from 0 to 1, the walker's pointer is reloaded and the channel is launched. When it goes from 1 to 0 while data is still moving, the channel stays active until the walker reports that it is idle, so a partial transfer is never cut off. The walker's completion and error indications are collected into the status register. A rising level on the device interrupt sets a sticky interrupt flag. The interrupt level itself passes straight through to the host interrupt line.

Top module: `bmdma_regs`

## Requirements
- R1: After reset, every register reads as zero. The active, reload and kick outputs are low and the table base is zero.
- R2: When a command write (select 0) changes the start bit (bit 0) from 0 to 1 on an idle channel, several things happen in the cycle after the write edge: `dma_active` is high, `status` bit 0 reads 1, and `reload_ptr` and `kick` are high for exactly that one cycle.
- R3: A command write whose start bit equals the stored start bit produces no reload or kick pulse and does not change the active flag.
- R4: A command write that changes start from 1 to 0 clears the active flag at the write edge if `xfer_busy` is low. Otherwise the active flag stays set until the first edge at which `xfer_busy` is sampled low.
- R5: The command register stores only bit 0 (start) and bit 3 (direction). All other bits of a command read return 0.
- R6: A base write (select 2) replaces only the bytes from the offset up to the offset plus the width. Width code 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. Data byte k goes to register byte offset+k. Base bits 1:0 always read 0.
- R7: A base read returns the register shifted right by 8×offset bits and masked to the access width.
- R8: A 0-to-1 change of `dev_irq` sets status bit 2. `host_irq` equals `dev_irq` at all times. A low or steady level leaves bit 2 unchanged.
- R9: An `eng_err` pulse sets status bit 1. An `eng_done` pulse clears the active flag and any pending stop.
- R10: A status write (select 1) clears bit 1 or bit 2 where the written data bit is 1. Bit 0 cannot be written. A set arriving in the same cycle wins over the clear.
- R11: A 0-to-1 start write while a stop is still pending keeps the channel active, cancels the stop and pulses `reload_ptr`, but gives no `kick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 command, 1 status, 2 base, 3 unused |
| reg_off | input | 2 | Byte offset (base register only) |
| reg_size | input | 2 | Access width code: 0 = 1 B, 1 = 2 B, else 4 B |
| reg_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| reg_rdata | output | 32 | Read data for the current select, combinational |
| xfer_busy | input | 1 | Walker has data in flight |
| eng_done | input | 1 | Walker completion pulse |
| eng_err | input | 1 | Walker error pulse |
| dev_irq | input | 1 | Device interrupt level |
| host_irq | output | 1 | Interrupt line towards the host |
| dma_active | output | 1 | Channel active flag |
| dma_dir | output | 1 | Stored direction bit |
| table_base | output | 32 | Descriptor table base address |
| reload_ptr | output | 1 | Pulse: reload the current descriptor pointer |
| kick | output | 1 | Pulse: start a transfer |

## Verification
Every register update lands at the clock edge that samples the write or the walker pulse. The state is visible on `reg_rdata`, `dma_active` and `table_base` in the cycle that follows, and the reload and kick pulses are valid only in that cycle. `host_irq` is combinational, so it is due in the same cycle as `dev_irq`.

The bench drives inputs just after a falling edge and updates its reference model at the rising edge. It compares every output at the next falling edge, so each check sits exactly one register stage after its stimulus. A stop held back by `xfer_busy` is watched over several cycles, which confirms that the active flag falls only at the edge that samples the walker idle.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_BASE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CMD_START = 0;
  localparam int CMD_DIR   = 3;
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_INT    = 2;

  function automatic int unsigned width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/bmdma_cmd_ctl.sv
module bmdma_cmd_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic wr_start,
  input  logic wr_dir,
  input  logic xfer_busy,
  input  logic eng_done,
  output logic start_o,
  output logic dir_o,
  output logic active_o,
  output logic reload_o,
  output logic kick_o
);

  logic start_q, dir_q, act_q, pend_q, reload_q, kick_q;
  logic start_d, dir_d, act_d, pend_d, reload_d, kick_d;
  logic drain_done;

  assign drain_done = pend_q && !xfer_busy;

  always_comb begin
    start_d  = start_q;
    dir_d    = dir_q;
    act_d    = act_q;
    pend_d   = pend_q;
    reload_d = 1'b0;
    kick_d   = 1'b0;
    if (eng_done || drain_done) begin
      act_d  = 1'b0;
      pend_d = 1'b0;
    end
    if (cmd_wr) begin
      start_d = wr_start;
      dir_d   = wr_dir;
      if (wr_start && !start_q) begin
        reload_d = 1'b1;
        pend_d   = 1'b0;
        if (!act_d) begin
          act_d  = 1'b1;
          kick_d = 1'b1;
        end
      end else if (!wr_start && start_q) begin
        if (xfer_busy) begin
          pend_d = act_d;
        end else begin
          act_d  = 1'b0;
          pend_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      dir_q    <= 1'b0;
      act_q    <= 1'b0;
      pend_q   <= 1'b0;
      reload_q <= 1'b0;
      kick_q   <= 1'b0;
    end else begin
      if (cmd_wr) begin
        start_q <= start_d;
        dir_q   <= dir_d;
      end
      act_q    <= act_d;
      pend_q   <= pend_d;
      reload_q <= reload_d;
      kick_q   <= kick_d;
    end
  end

  assign start_o  = start_q;
  assign dir_o    = dir_q;
  assign active_o = act_q;
  assign reload_o = reload_q;
  assign kick_o   = kick_q;

  // R2
  start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_start && !start_q) |=> (reload_q && act_q));

  // R3
  same_start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (wr_start == start_q)) |=> (!reload_q && !kick_q));

  // R4
  stop_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && xfer_busy && !eng_done) |=> act_q);

  // R11
  restart_no_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_start && !start_q && act_q && !eng_done && !drain_done)
    |=> (act_q && !kick_q));

endmodule

// File: rtl/bmdma_base_reg.sv
module bmdma_base_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic [1:0]        off,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] rd_o
);
  import bmdma_pkg::*;

  localparam int NB = ADDR_W / 8;

  logic [ADDR_W-1:0] base_q, base_d, lane_data, rd_mask;
  logic [NB-1:0]     lane_en;
  int unsigned       nbytes;

  assign nbytes    = width_bytes(size);
  assign lane_data = wdata << {off, 3'b000};

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_en[g] = base_wr && (g >= int'(off)) && (g < int'(off) + int'(nbytes));
    assign rd_mask[8*g +: 8] = (g < int'(nbytes)) ? 8'hFF : 8'h00;

    // R6
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_en[g] |=> $stable(base_q[8*g +: 8]));
  end

  always_comb begin
    base_d = base_q;
    for (int i = 0; i < NB; i++) begin
      if (lane_en[i]) base_d[8*i +: 8] = lane_data[8*i +: 8];
    end
    base_d[1:0] = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (base_wr) base_q <= base_d;
  end

  assign base_o = base_q;
  assign rd_o   = (base_q >> {off, 3'b000}) & rd_mask;

endmodule

// File: rtl/bmdma_status.sv
module bmdma_status (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_wr,
  input  logic clr_err,
  input  logic clr_int,
  input  logic eng_err,
  input  logic dev_irq,
  output logic err_o,
  output logic int_o
);

  logic err_q, int_q, irq_prev_q;
  logic err_d, int_d, irq_rise;

  assign irq_rise = dev_irq && !irq_prev_q;

  always_comb begin
    err_d = err_q;
    int_d = int_q;
    if (stat_wr && clr_err) err_d = 1'b0;
    if (stat_wr && clr_int) int_d = 1'b0;
    if (eng_err)  err_d = 1'b1;
    if (irq_rise) int_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q      <= 1'b0;
      int_q      <= 1'b0;
      irq_prev_q <= 1'b0;
    end else begin
      err_q      <= err_d;
      int_q      <= int_d;
      irq_prev_q <= dev_irq;
    end
  end

  assign err_o = err_q;
  assign int_o = int_q;

  // R8
  irq_rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq && !irq_prev_q) |=> int_q);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(stat_wr && clr_err)) |=> err_q);

  // R10
  w1c_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && clr_err && !eng_err) |=> !err_q);

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [1:0]        reg_off,
  input  logic [1:0]        reg_size,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              xfer_busy,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              dev_irq,
  output logic              host_irq,
  output logic              dma_active,
  output logic              dma_dir,
  output logic [ADDR_W-1:0] table_base,
  output logic              reload_ptr,
  output logic              kick
);
  import bmdma_pkg::*;

  reg_sel_e          sel;
  logic              cmd_wr, stat_wr, base_wr;
  logic              start_bit, err_bit, int_bit;
  logic [ADDR_W-1:0] base_rd;

  assign sel     = reg_sel_e'(reg_sel);
  assign cmd_wr  = reg_wr && (sel == SEL_CMD);
  assign stat_wr = reg_wr && (sel == SEL_STAT);
  assign base_wr = reg_wr && (sel == SEL_BASE);

  bmdma_cmd_ctl u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .wr_start (reg_wdata[CMD_START]),
    .wr_dir   (reg_wdata[CMD_DIR]),
    .xfer_busy(xfer_busy),
    .eng_done (eng_done),
    .start_o  (start_bit),
    .dir_o    (dma_dir),
    .active_o (dma_active),
    .reload_o (reload_ptr),
    .kick_o   (kick)
  );

  bmdma_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk    (clk),
    .rst_n  (rst_n),
    .base_wr(base_wr),
    .off    (reg_off),
    .size   (reg_size),
    .wdata  (reg_wdata),
    .base_o (table_base),
    .rd_o   (base_rd)
  );

  bmdma_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat_wr(stat_wr),
    .clr_err(reg_wdata[ST_ERR]),
    .clr_int(reg_wdata[ST_INT]),
    .eng_err(eng_err),
    .dev_irq(dev_irq),
    .err_o  (err_bit),
    .int_o  (int_bit)
  );

  assign host_irq = dev_irq;

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CMD: begin
        reg_rdata[CMD_START] = start_bit;
        reg_rdata[CMD_DIR]   = dma_dir;
      end
      SEL_STAT: begin
        reg_rdata[ST_ACT] = dma_active;
        reg_rdata[ST_ERR] = err_bit;
        reg_rdata[ST_INT] = int_bit;
      end
      SEL_BASE: reg_rdata = base_rd;
      default:  reg_rdata = '0;
    endcase
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (!dma_active && !reload_ptr && !kick && (table_base == '0)));

  // R8
  irq_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_irq) |-> host_irq);

endmodule

// File: tb/sim_bmdma_regs.sv
module sim_bmdma_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_sel, reg_off, reg_size;
  logic [31:0] reg_wdata, reg_rdata, table_base;
  logic        xfer_busy, eng_done, eng_err, dev_irq;
  logic        host_irq, dma_active, dma_dir, reload_ptr, kick;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit          m_start, m_dir, m_act, m_pend, m_reload, m_kick, m_err, m_int, m_prev;
  logic [31:0] m_base;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmdma_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_off(reg_off), .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .xfer_busy(xfer_busy), .eng_done(eng_done),
    .eng_err(eng_err), .dev_irq(dev_irq), .host_irq(host_irq),
    .dma_active(dma_active), .dma_dir(dma_dir), .table_base(table_base),
    .reload_ptr(reload_ptr), .kick(kick)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_start = 0; m_dir = 0; m_act = 0; m_pend = 0; m_reload = 0;
    m_kick = 0; m_err = 0; m_int = 0; m_prev = 0; m_base = '0;
  endtask

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  task automatic model_update();
    bit na, np, nr, nk, ne, ni;
    if (!rst_n) begin model_reset(); return; end
    na = m_act; np = m_pend; nr = 0; nk = 0;
    if (eng_done || (m_pend && !xfer_busy)) begin na = 0; np = 0; end
    if (reg_wr && reg_sel == 2'd0) begin
      if (reg_wdata[0] && !m_start) begin
        nr = 1; np = 0;
        if (!na) begin na = 1; nk = 1; end
      end else if (!reg_wdata[0] && m_start) begin
        if (xfer_busy) np = na;
        else begin na = 0; np = 0; end
      end
      m_start = reg_wdata[0];
      m_dir   = reg_wdata[3];
    end
    ne = m_err; ni = m_int;
    if (reg_wr && reg_sel == 2'd1 && reg_wdata[1]) ne = 0;
    if (reg_wr && reg_sel == 2'd1 && reg_wdata[2]) ni = 0;
    if (eng_err) ne = 1;
    if (dev_irq && !m_prev) ni = 1;
    m_prev = dev_irq;
    if (reg_wr && reg_sel == 2'd2) begin
      for (int b = 0; b < 4; b++)
        if (b >= int'(reg_off) && b < int'(reg_off) + nbytes(reg_size))
          m_base[8*b +: 8] = reg_wdata[8*(b - int'(reg_off)) +: 8];
      m_base[1:0] = 2'b00;
    end
    m_act = na; m_pend = np; m_reload = nr; m_kick = nk; m_err = ne; m_int = ni;
  endtask

  task automatic compare();
    logic [31:0] er;
    string tag;
    chk("R4", "dma_active", {31'b0, dma_active}, {31'b0, m_act});
    chk("R2", "reload_ptr", {31'b0, reload_ptr}, {31'b0, m_reload});
    chk("R2", "kick", {31'b0, kick}, {31'b0, m_kick});
    chk("R5", "dma_dir", {31'b0, dma_dir}, {31'b0, m_dir});
    chk("R6", "table_base", table_base, m_base);
    chk("R8", "host_irq", {31'b0, host_irq}, {31'b0, dev_irq});
    case (reg_sel)
      2'd0: begin er = {28'b0, m_dir, 2'b0, m_start}; tag = "R5"; end
      2'd1: begin er = {29'b0, m_int, m_err, m_act}; tag = "R10"; end
      2'd2: begin
        er = m_base >> (8 * int'(reg_off));
        if (nbytes(reg_size) < 4) er = er & ((32'd1 << (8 * nbytes(reg_size))) - 1);
        tag = "R7";
      end
      default: begin er = '0; tag = "R7"; end
    endcase
    chk(tag, "reg_rdata", reg_rdata, er);
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] off,
                    input logic [1:0] sz, input logic [31:0] d);
    reg_wr = 1; reg_sel = sel; reg_off = off; reg_size = sz; reg_wdata = d;
    tick();
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [1:0] off, input logic [1:0] sz);
    reg_sel = sel; reg_off = off; reg_size = sz;
    tick();
  endtask

  task automatic pulse_done();
    eng_done = 1; tick(); eng_done = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_sel = 0; reg_off = 0; reg_size = 0; reg_wdata = 0;
    xfer_busy = 0; eng_done = 0; eng_err = 0; dev_irq = 0;
    model_reset();
    idle(3);
    rst_n = 1;
    idle(2);
    // R1: reset state of every register
    rd(2'd0, 0, 2); chk("R1", "cmd after reset", reg_rdata, 32'h0);
    rd(2'd1, 0, 2); chk("R1", "status after reset", reg_rdata, 32'h0);
    rd(2'd2, 0, 2); chk("R1", "base after reset", reg_rdata, 32'h0);

    // R6: full and partial base writes
    wr(2'd2, 0, 2, 32'h1234_5677);
    chk("R6", "full write low bits forced", table_base, 32'h1234_5674);
    rd(2'd2, 1, 0); chk("R7", "byte read off1", reg_rdata, 32'h56);
    rd(2'd2, 2, 1); chk("R7", "half read off2", reg_rdata, 32'h1234);
    wr(2'd2, 2, 0, 32'hFFFF_FFAB);
    chk("R6", "byte write off2", table_base, 32'h12AB_5674);
    wr(2'd2, 1, 1, 32'h0000_CDEF);
    chk("R6", "half write off1", table_base, 32'h12CD_EF74);
    wr(2'd2, 0, 0, 32'h0000_00FF);
    chk("R6", "byte write off0", table_base, 32'h12CD_EFFC);
    rd(2'd2, 3, 2); chk("R7", "wide read off3", reg_rdata, 32'h12);

    // R5 + R2: start with junk bits set
    reg_sel = 2'd0;
    wr(2'd0, 0, 0, 32'hFF);
    chk("R2", "kick on start", {31'b0, kick}, 32'd1);
    chk("R2", "reload on start", {31'b0, reload_ptr}, 32'd1);
    chk("R5", "cmd readback", reg_rdata, 32'h09);
    idle(1);
    chk("R2", "reload one cycle", {31'b0, reload_ptr}, 32'd0);
    // R3: same start value
    wr(2'd0, 0, 0, 32'h09);
    chk("R3", "no reload on same start", {31'b0, reload_ptr}, 32'd0);
    wr(2'd0, 0, 0, 32'h01);
    chk("R3", "active kept on dir write", {31'b0, dma_active}, 32'd1);

    // R9 / R10: error latching and W1C
    eng_err = 1; tick(); eng_err = 0;
    rd(2'd1, 0, 0); chk("R9", "err set", reg_rdata, 32'h3);
    wr(2'd1, 0, 0, 32'h01);
    chk("R10", "active not writable", reg_rdata, 32'h3);
    wr(2'd1, 0, 0, 32'h02);
    chk("R10", "err cleared", reg_rdata, 32'h1);
    eng_err = 1; reg_wr = 1; reg_sel = 2'd1; reg_wdata = 32'h02; tick();
    reg_wr = 0; eng_err = 0;
    chk("R10", "set beats clear", reg_rdata, 32'h3);
    wr(2'd1, 0, 0, 32'h02);

    // R8: interrupt latching
    dev_irq = 1; #1;
    chk("R8", "host_irq same cycle", {31'b0, host_irq}, 32'd1);
    tick();
    chk("R8", "int set on rise", reg_rdata, 32'h5);
    wr(2'd1, 0, 0, 32'h04);
    idle(2);
    chk("R8", "steady high no reset", reg_rdata, 32'h1);
    dev_irq = 0; idle(2);
    chk("R8", "low level untouched", reg_rdata, 32'h1);

    // R4: stop while busy drains
    xfer_busy = 1;
    wr(2'd0, 0, 0, 32'h00);
    idle(3);
    chk("R4", "active held while busy", {31'b0, dma_active}, 32'd1);
    xfer_busy = 0; tick();
    chk("R4", "active cleared after drain", {31'b0, dma_active}, 32'd0);

    // R11: restart while stop pending
    wr(2'd0, 0, 0, 32'h01);
    xfer_busy = 1;
    wr(2'd0, 0, 0, 32'h00);
    wr(2'd0, 0, 0, 32'h01);
    chk("R11", "no kick on restart", {31'b0, kick}, 32'd0);
    chk("R11", "reload on restart", {31'b0, reload_ptr}, 32'd1);
    xfer_busy = 0; idle(2);
    chk("R11", "stop cancelled", {31'b0, dma_active}, 32'd1);
    // R9: completion clears active
    pulse_done();
    chk("R9", "done clears active", {31'b0, dma_active}, 32'd0);

    // R4: stop without busy is immediate
    wr(2'd0, 0, 0, 32'h00);
    wr(2'd0, 0, 0, 32'h01);
    wr(2'd0, 0, 0, 32'h00);
    chk("R4", "immediate stop", {31'b0, dma_active}, 32'd0);

    // R1: reset while running
    wr(2'd0, 0, 0, 32'h09);
    eng_err = 1; tick(); eng_err = 0;
    rst_n = 0; tick();
    chk("R1", "active after mid reset", {31'b0, dma_active}, 32'd0);
    chk("R1", "base after mid reset", table_base, 32'h0);
    rst_n = 1;
    rd(2'd1, 0, 0); chk("R1", "status after mid reset", reg_rdata, 32'h0);
    rd(2'd0, 0, 0); chk("R1", "cmd after mid reset", reg_rdata, 32'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule